// File: doc/BRIEF.md
# Predicated Bfloat16 Vector Fused Multiply-Add

This block performs a lane-wise fused multiply-add on vectors of 16-bit bfloat16 elements. It takes two multiplicand vectors and an addend vector, all `VL` bits wide. Each active lane returns `c + a*b` with one rounding to nearest-even. Each result replaces the addend lane, so the output vector stands in for the third source. Two optional controls flip the sign of the first multiplicand and of the addend before the operation.

A byte-granular predicate of `VL/8` bits selects the lanes. Lane `e` uses only bit `2e`. A masked lane returns its addend bit for bit. When no lane is selected, both multiplicands are forced to zero before use.

One register stage sits between a valid/ready input handshake and a valid/ready output handshake. A pipeline can use the block as a stage that accepts one vector per cycle while the consumer keeps up.

Top module: `bf16_vec_fma`

## Requirements
- R1: Lane `e` occupies bits `[16e+15:16e]` of `src_a_i`, `src_b_i`, `src_c_i` and `res_o`. The lane is active exactly when `pred_i[2e]` is 1. Odd predicate bits have no effect.
- R2: For an inactive lane, the `res_o` lane equals the `src_c_i` lane of the same operation, bit for bit, including NaN encodings.
- R3: For an active lane with finite operands, the result is the exact value `c + a*b` rounded once to bfloat16. The format is sign in bit 15, biased-127 exponent in bits 14:7 and fraction in bits 6:0. Rounding is to nearest with ties to even. Subnormal inputs and results are handled with gradual underflow.
- R4: When `neg_a_i` is 1, the sign of every `a` lane is inverted before the multiply. When `neg_c_i` is 1, the sign of every `c` lane is inverted before the add. Inactive lanes are not affected by either control.
- R5: An active lane returns `16'h7FC0` in three cases: any input is NaN (exponent 255, fraction nonzero); infinity is multiplied by zero; or an infinite product meets an infinite addend of opposite sign.
- R6: An exact zero sum of nonzero terms returns +0. A zero product plus a zero addend returns -0 only when both are negative, and +0 otherwise.
- R7: A finite result whose rounded magnitude reaches 2^128 returns an infinity with the result's sign (`16'h7F80` or `16'hFF80`).
- R8: With no even predicate bit set, the whole output vector equals `src_c_i`.
- R9: An operation is accepted on a cycle with `valid_i` and `ready_o` both high. Its result appears with `valid_o` high on the next cycle. While `valid_o` is high and `ready_i` is low, `res_o` and `valid_o` hold and `ready_o` is low. Otherwise `ready_o` is high.
- R10: While `rst_ni` is low, `valid_o` is 0 and `ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands and controls are presented |
| ready_o | output | 1 | Block can take an operation this cycle |
| neg_a_i | input | 1 | Invert the sign of the first multiplicand |
| neg_c_i | input | 1 | Invert the sign of the addend |
| pred_i | input | VL/8 | Byte predicate; bit 2e governs lane e |
| src_a_i | input | VL | First multiplicand vector |
| src_b_i | input | VL | Second multiplicand vector |
| src_c_i | input | VL | Addend vector |
| valid_o | output | 1 | Result vector is presented |
| ready_i | input | 1 | Consumer takes the result this cycle |
| res_o | output | VL | Result vector, replacing the addend |

## Verification
Every result is due exactly one clock edge after the edge that accepts its operation. This holds for fused lanes and pass-through lanes alike, because all lanes share the single output register. The bench drives operands on the falling edge and releases `valid_i` on the next falling edge. It then reads `valid_o` and every lane at that falling edge, half a cycle after the register loads. Under backpressure, the bench samples again on each held cycle. After releasing `ready_i`, it reads the queued operation one edge later.

// File: rtl/vfma_pkg.sv
`timescale 1ns/1ps
package vfma_pkg;
  localparam int unsigned BF_W    = 16;
  localparam int unsigned EXP_W   = 8;
  localparam int unsigned FRAC_W  = 7;
  localparam int          BIAS    = 127;
  localparam logic [BF_W-1:0] DFLT_NAN = 16'h7FC0;

  typedef logic signed [11:0] exp_t;

  // leading zero count; callers pad the low bits with ones
  function automatic logic [5:0] lzc32(input logic [31:0] v);
    logic [5:0] n;
    n = 6'd32;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) n = 6'(31 - i);
    end
    return n;
  endfunction
endpackage

// File: rtl/vfma_pred_gate.sv
`timescale 1ns/1ps
module vfma_pred_gate #(
  parameter int unsigned LANES = 4,
  localparam int unsigned VW = 16 * LANES
) (
  input  logic [2*LANES-1:0] pred_i,
  input  logic [VW-1:0]      a_i,
  input  logic [VW-1:0]      b_i,
  output logic [LANES-1:0]   act_o,
  output logic [VW-1:0]      a_o,
  output logic [VW-1:0]      b_o
);
  logic [LANES-1:0] odd_bits;
  logic             any_act;
  logic             unused_pred_odd;

  for (genvar e = 0; e < LANES; e++) begin : g_dec
    assign act_o[e]    = pred_i[2*e];
    assign odd_bits[e] = pred_i[2*e+1];
  end

  assign any_act         = |act_o;
  assign unused_pred_odd = ^odd_bits;
  assign a_o = any_act ? a_i : '0;
  assign b_o = any_act ? b_i : '0;
endmodule

// File: rtl/vfma_round.sv
`timescale 1ns/1ps
module vfma_round import vfma_pkg::*; #(
  parameter int unsigned MW = 21
) (
  input  logic [MW-1:0] mag_i,
  input  exp_t          lsb_exp_i,
  input  logic          sign_i,
  output logic [15:0]   res_o
);
  localparam int unsigned XW = MW + 10;
  localparam int unsigned SH_MAX = XW + 2;

  logic [5:0]     lz;
  exp_t           msb_exp, msb_c, rsh, ebias, efin;
  logic [5:0]     sh;
  logic [XW-1:0]  ext;
  logic [2*XW+1:0] t;
  logic [8:0]     m, mr;
  logic           rnd_bit, stk, inc;
  logic           unused_hi;

  assign lz      = lzc32({mag_i, {(32-MW){1'b1}}});
  assign msb_exp = lsb_exp_i + exp_t'(MW - 1) - $signed({6'b0, lz});
  assign msb_c   = (msb_exp < -12'sd126) ? -12'sd126 : msb_exp;
  // right shift of the 10-bit-extended magnitude to the result quantum
  assign rsh     = msb_c - 12'sd7 - lsb_exp_i + 12'sd10;
  assign sh      = (rsh > exp_t'(SH_MAX)) ? 6'(SH_MAX) : (rsh < 0) ? 6'd0 : rsh[5:0];
  assign ext     = {mag_i, 10'b0};
  assign t       = {ext, {(XW+2){1'b0}}} >> sh;
  assign m       = t[XW+10:XW+2];
  assign rnd_bit = t[XW+1];
  assign stk     = |t[XW:0];
  assign unused_hi = ^t[2*XW+1:XW+11];
  assign inc     = rnd_bit & (stk | m[0]);
  assign mr      = m + 9'(inc);
  assign ebias   = msb_c + exp_t'(BIAS);

  always_comb begin
    if (mr[8])      efin = ebias + 12'sd1;
    else if (mr[7]) efin = ebias;
    else            efin = '0;
    if (efin >= 12'sd255) res_o = {sign_i, 8'hFF, 7'd0};
    else if (mr[8])       res_o = {sign_i, efin[7:0], 7'd0};
    else                  res_o = {sign_i, efin[7:0], mr[6:0]};
  end
endmodule

// File: rtl/vfma_lane.sv
`timescale 1ns/1ps
module vfma_lane import vfma_pkg::*; (
  input  logic [15:0] a_i,
  input  logic [15:0] b_i,
  input  logic [15:0] c_i,
  input  logic        neg_a_i,
  input  logic        neg_c_i,
  output logic [15:0] res_o
);
  localparam int unsigned GB = 4;          // guard bits incl. sticky slot
  localparam int unsigned WW = 16 + GB;

  logic       sa, sb, sc, ps;
  logic [7:0] ea, eb, ec, ma, mb, mc;
  logic [6:0] fa, fb, fc;
  logic a_zero, b_zero, c_zero, a_inf, b_inf, c_inf, a_nan, b_nan, c_nan;
  exp_t xa, xb, xc, pe, pen, cen, big_e, small_e, dexp, wl;
  logic [15:0] pm, pn, cw, cn, big_sig, small_sig;
  logic [5:0]  lzp, lzq;
  logic        swap, big_s, small_s, sub;
  logic [WW-1:0] full, shv, sw, bw;
  logic          stk;
  logic signed [WW+1:0] dsum;
  logic [WW:0]   mag;
  logic          rsgn;
  logic [15:0]   rnd;

  assign sa = a_i[15] ^ neg_a_i;
  assign sb = b_i[15];
  assign sc = c_i[15] ^ neg_c_i;
  assign ps = sa ^ sb;
  assign {ea, fa} = a_i[14:0];
  assign {eb, fb} = b_i[14:0];
  assign {ec, fc} = c_i[14:0];

  assign a_zero = (ea == 8'd0) && (fa == 7'd0);
  assign b_zero = (eb == 8'd0) && (fb == 7'd0);
  assign c_zero = (ec == 8'd0) && (fc == 7'd0);
  assign a_inf  = (ea == 8'hFF) && (fa == 7'd0);
  assign b_inf  = (eb == 8'hFF) && (fb == 7'd0);
  assign c_inf  = (ec == 8'hFF) && (fc == 7'd0);
  assign a_nan  = (ea == 8'hFF) && (fa != 7'd0);
  assign b_nan  = (eb == 8'hFF) && (fb != 7'd0);
  assign c_nan  = (ec == 8'hFF) && (fc != 7'd0);

  assign ma = {|ea, fa};
  assign mb = {|eb, fb};
  assign mc = {|ec, fc};
  // exponent of the significand lsb
  assign xa = $signed({4'b0, (ea == 8'd0) ? 8'd1 : ea}) - 12'sd134;
  assign xb = $signed({4'b0, (eb == 8'd0) ? 8'd1 : eb}) - 12'sd134;
  assign xc = $signed({4'b0, (ec == 8'd0) ? 8'd1 : ec}) - 12'sd134;

  // exact product, then both terms normalised to bit 15
  assign pm  = 16'(ma) * 16'(mb);
  assign pe  = xa + xb;
  assign lzp = lzc32({pm, 16'hFFFF});
  assign pn  = pm << lzp[4:0];
  assign pen = pe - $signed({6'b0, lzp});
  assign cw  = {mc, 8'b0};
  assign lzq = lzc32({cw, 16'hFFFF});
  assign cn  = cw << lzq[4:0];
  assign cen = xc - 12'sd8 - $signed({6'b0, lzq});

  assign swap      = !c_zero && (cen > pen);
  assign big_sig   = swap ? cn : pn;
  assign big_e     = swap ? cen : pen;
  assign big_s     = swap ? sc : ps;
  assign small_sig = swap ? pn : cn;
  assign small_e   = swap ? pen : cen;
  assign small_s   = swap ? ps : sc;
  assign dexp      = big_e - small_e;
  assign full      = {small_sig, {GB{1'b0}}};

  always_comb begin
    if (dexp >= exp_t'(WW)) begin
      shv = '0;
      stk = |full;
    end else begin
      shv = full >> dexp[4:0];
      stk = |(full & ((WW'(1) << dexp[4:0]) - WW'(1)));
    end
  end

  assign sw   = {shv[WW-1:1], shv[0] | stk};
  assign bw   = {big_sig, {GB{1'b0}}};
  assign sub  = big_s ^ small_s;
  assign dsum = sub ? ($signed({2'b0, bw}) - $signed({2'b0, sw}))
                    : ($signed({2'b0, bw}) + $signed({2'b0, sw}));
  assign mag  = dsum[WW+1] ? WW'(-dsum) : dsum[WW:0];
  assign rsgn = dsum[WW+1] ? small_s : big_s;
  assign wl   = big_e - exp_t'(GB);

  vfma_round #(.MW(WW+1)) u_rnd (
    .mag_i    (mag),
    .lsb_exp_i(wl),
    .sign_i   (rsgn),
    .res_o    (rnd)
  );

  always_comb begin
    if (a_nan || b_nan || c_nan)                  res_o = DFLT_NAN;
    else if ((a_inf && b_zero) || (b_inf && a_zero)) res_o = DFLT_NAN;
    else if (a_inf || b_inf) begin
      if (c_inf && (sc != ps))                    res_o = DFLT_NAN;
      else                                        res_o = {ps, 8'hFF, 7'd0};
    end
    else if (c_inf)                               res_o = {sc, 8'hFF, 7'd0};
    else if (a_zero || b_zero) begin
      if (c_zero)                                 res_o = {ps & sc, 15'd0};
      else                                        res_o = {sc, c_i[14:0]};
    end
    else if (mag == '0)                           res_o = 16'h0000;
    else                                          res_o = rnd;
  end
endmodule

// File: rtl/bf16_vec_fma.sv
`timescale 1ns/1ps
module bf16_vec_fma import vfma_pkg::*; #(
  parameter int unsigned VL = 64,
  localparam int unsigned LANES = VL / BF_W,
  localparam int unsigned PW = VL / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  output logic          ready_o,
  input  logic          neg_a_i,
  input  logic          neg_c_i,
  input  logic [PW-1:0] pred_i,
  input  logic [VL-1:0] src_a_i,
  input  logic [VL-1:0] src_b_i,
  input  logic [VL-1:0] src_c_i,
  output logic          valid_o,
  input  logic          ready_i,
  output logic [VL-1:0] res_o
);
  logic [LANES-1:0] act;
  logic [VL-1:0]    a_g, b_g, res_d, res_q;
  logic             valid_q;
  logic             accept;

  vfma_pred_gate #(.LANES(LANES)) u_gate (
    .pred_i(pred_i),
    .a_i   (src_a_i),
    .b_i   (src_b_i),
    .act_o (act),
    .a_o   (a_g),
    .b_o   (b_g)
  );

  for (genvar e = 0; e < LANES; e++) begin : g_lane
    logic [15:0] fma_r;
    vfma_lane u_lane (
      .a_i    (a_g[16*e +: 16]),
      .b_i    (b_g[16*e +: 16]),
      .c_i    (src_c_i[16*e +: 16]),
      .neg_a_i(neg_a_i),
      .neg_c_i(neg_c_i),
      .res_o  (fma_r)
    );
    assign res_d[16*e +: 16] = act[e] ? fma_r : src_c_i[16*e +: 16];
  end

  assign ready_o = !valid_q || ready_i;
  assign accept  = valid_i && ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      if (accept)       valid_q <= 1'b1;
      else if (ready_i) valid_q <= 1'b0;
      if (accept)       res_q   <= res_d;
    end
  end

  assign valid_o = valid_q;
  assign res_o   = res_q;
endmodule

// File: rtl/vfma_chk.sv
`timescale 1ns/1ps
module vfma_chk #(
  parameter int unsigned VL = 64,
  localparam int unsigned LANES = VL / 16,
  localparam int unsigned PW = VL / 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic          ready_o,
  input logic          neg_a_i,
  input logic          neg_c_i,
  input logic [PW-1:0] pred_i,
  input logic [VL-1:0] src_a_i,
  input logic [VL-1:0] src_b_i,
  input logic [VL-1:0] src_c_i,
  input logic          valid_o,
  input logic          ready_i,
  input logic [VL-1:0] res_o
);
  logic unused_chk;
  assign unused_chk = ^{neg_a_i, neg_c_i, src_b_i};

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(res_o));

  a_r9_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |-> !ready_o);

  a_r9_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ready_o |=> valid_o);

  always @(posedge clk_i) begin
    if (!rst_ni) a_r10_reset: assert (!valid_o && ready_o);
  end

  for (genvar e = 0; e < LANES; e++) begin : g_chk
    a_r2_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i && ready_o && !pred_i[2*e] |=> res_o[16*e +: 16] == $past(src_c_i[16*e +: 16]));

    a_r5_nan: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i && ready_o && pred_i[2*e] && (src_a_i[16*e+7 +: 8] == 8'hFF) && (src_a_i[16*e +: 7] != 7'd0)
      |=> res_o[16*e +: 16] == 16'h7FC0);
  end
endmodule

bind bf16_vec_fma vfma_chk #(.VL(VL)) u_vfma_chk (.*);

// File: tb/bf16_vec_fma_tb_top.sv
`timescale 1ns/1ps
module bf16_vec_fma_tb_top;
  localparam int VL = 64;
  localparam int LANES = VL / 16;
  localparam int PW = VL / 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0, ready_i = 1'b1, neg_a_i = 1'b0, neg_c_i = 1'b0;
  logic [PW-1:0] pred_i = '0;
  logic [VL-1:0] src_a_i = '0, src_b_i = '0, src_c_i = '0;
  logic          ready_o, valid_o;
  logic [VL-1:0] res_o;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bf16_vec_fma #(.VL(VL)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .ready_o(ready_o),
    .neg_a_i(neg_a_i), .neg_c_i(neg_c_i), .pred_i(pred_i),
    .src_a_i(src_a_i), .src_b_i(src_b_i), .src_c_i(src_c_i),
    .valid_o(valid_o), .ready_i(ready_i), .res_o(res_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic real pow2(input int k);
    logic [10:0] be;
    be = 11'(k + 1023);
    return $bitstoreal({1'b0, be, 52'b0});
  endfunction

  function automatic real bf2real(input logic [15:0] x);
    real v;
    int  e;
    e = int'(x[14:7]);
    if (e == 0) v = real'(x[6:0]) * pow2(-133);
    else        v = (128.0 + real'(x[6:0])) * pow2(e - 134);
    return x[15] ? -v : v;
  endfunction

  function automatic logic [15:0] real2bf(input real v);
    logic        s;
    real         x, q, n, fl, fr;
    logic [63:0] bits;
    int          e, be;
    longint      mi;
    s = (v < 0.0);
    x = s ? -v : v;
    bits = $realtobits(x);
    e = int'(bits[62:52]) - 1023;
    if (e < -126) e = -126;
    q = pow2(e - 7);
    n = x / q;
    fl = $floor(n);
    fr = n - fl;
    mi = longint'(fl);
    if (fr > 0.5 || (fr == 0.5 && mi[0])) mi++;
    if (mi == 256) begin e++; mi = 128; end
    if (mi >= 128) be = e + 127; else be = 0;
    if (be >= 255) return {s, 8'hFF, 7'd0};
    return {s, 8'(be), 7'(mi & 127)};
  endfunction

  function automatic logic [15:0] ref_fma(input logic [15:0] a, input logic [15:0] b,
                                          input logic [15:0] c, input logic na, input logic nc);
    logic sa, sc, ps;
    logic an, bn, cn, ai, bi, ci, az, bz, cz;
    real  sum;
    sa = a[15] ^ na; sc = c[15] ^ nc; ps = sa ^ b[15];
    an = a[14:7] == 8'hFF && a[6:0] != 0; ai = a[14:7] == 8'hFF && a[6:0] == 0; az = a[14:0] == 0;
    bn = b[14:7] == 8'hFF && b[6:0] != 0; bi = b[14:7] == 8'hFF && b[6:0] == 0; bz = b[14:0] == 0;
    cn = c[14:7] == 8'hFF && c[6:0] != 0; ci = c[14:7] == 8'hFF && c[6:0] == 0; cz = c[14:0] == 0;
    if (an || bn || cn) return 16'h7FC0;
    if ((ai && bz) || (bi && az)) return 16'h7FC0;
    if (ai || bi) return (ci && sc != ps) ? 16'h7FC0 : {ps, 8'hFF, 7'd0};
    if (ci) return {sc, 8'hFF, 7'd0};
    if ((az || bz) && cz) return {ps & sc, 15'd0};
    sum = bf2real({sa, a[14:0]}) * bf2real(b) + bf2real({sc, c[14:0]});
    if (sum == 0.0) return 16'h0000;
    return real2bf(sum);
  endfunction

  function automatic logic [15:0] rnd_bf(input int lo, input int hi);
    logic [31:0] r;
    r = $urandom;
    return {r[0], 8'(lo + int'(r[15:8]) % (hi - lo + 1)), r[22:16]};
  endfunction

  // drive one operation, sample one cycle after acceptance, compare every lane
  task automatic run_vec(input string req, input logic [VL-1:0] a, input logic [VL-1:0] b,
                         input logic [VL-1:0] c, input logic [PW-1:0] p,
                         input logic na, input logic nc);
    logic [VL-1:0] exp_v;
    for (int e = 0; e < LANES; e++) begin
      if (p[2*e]) exp_v[16*e +: 16] = ref_fma(a[16*e +: 16], b[16*e +: 16], c[16*e +: 16], na, nc);
      else        exp_v[16*e +: 16] = c[16*e +: 16];
    end
    @(negedge clk);
    src_a_i = a; src_b_i = b; src_c_i = c; pred_i = p; neg_a_i = na; neg_c_i = nc; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    check({req, " valid"}, 64'(valid_o), 64'd1);
    for (int e = 0; e < LANES; e++)
      check(req, 64'(res_o[16*e +: 16]), 64'(exp_v[16*e +: 16]));
  endtask

  task automatic t_reset;
    #1;
    check("R10 valid_o in reset", 64'(valid_o), 64'd0);
    check("R10 ready_o in reset", 64'(ready_o), 64'd1);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R10 valid_o after reset", 64'(valid_o), 64'd0);
  endtask

  task automatic t_basic;
    // 2*3+1 = 7 in every lane
    run_vec("R3 basic", {LANES{16'h4000}}, {LANES{16'h4040}}, {LANES{16'h3F80}}, {PW{1'b1}}, 0, 0);
    check("R3 literal 7.0", 64'(res_o[15:0]), 64'h40E0);
    // tie at 1+2^-8 rounds to even, fused cancellation, sticky tie break
    run_vec("R3 rounding", {16'h3F81, 16'h3F81, 16'h3F80, 16'h3F80},
            {16'h3F81, 16'h3F81, 16'h3F80, 16'h3F80},
            {16'h3B81, 16'hBF80, 16'h3BC0, 16'h3B80}, {PW{1'b1}}, 0, 0);
    check("R3 tie to even", 64'(res_o[15:0]), 64'h3F80);
  endtask

  task automatic t_predicate;
    logic [VL-1:0] a, b, c;
    a = {16'h4000, 16'h4040, 16'h3F80, 16'h4100};
    b = {16'h4040, 16'h4000, 16'h4000, 16'hC000};
    c = {16'h7FC1, 16'h1234, 16'hFF80, 16'h3F80};
    run_vec("R1 even lanes", a, b, c, 8'b0000_0101, 0, 0);
    run_vec("R2 odd bits only", a, b, c, 8'b1010_1010, 0, 0);
    check("R8 no active lane", 64'(res_o), 64'(c));
    run_vec("R1 lane 3 only", a, b, c, 8'b0100_0000, 1, 1);
    check("R2 lane0 passthrough with negate", 64'(res_o[15:0]), 64'h3F80);
  endtask

  task automatic t_negate;
    run_vec("R4 neg a", {LANES{16'h4000}}, {LANES{16'h4040}}, {LANES{16'h3F80}}, {PW{1'b1}}, 1, 0);
    check("R4 -6+1", 64'(res_o[15:0]), 64'hC0A0);
    run_vec("R4 neg c", {LANES{16'h4000}}, {LANES{16'h4040}}, {LANES{16'h3F80}}, {PW{1'b1}}, 0, 1);
    check("R4 6-1", 64'(res_o[15:0]), 64'h40A0);
    run_vec("R4 neg both", {LANES{16'h4000}}, {LANES{16'h4040}}, {LANES{16'h3F80}}, {PW{1'b1}}, 1, 1);
    check("R4 -6-1", 64'(res_o[15:0]), 64'hC0E0);
  endtask

  task automatic t_specials;
    run_vec("R5 nan cases", {16'h7F80, 16'h7F80, 16'h3F80, 16'h7FA0},
            {16'h3F80, 16'h0000, 16'h7F81, 16'h3F80},
            {16'hFF80, 16'h3F80, 16'h0000, 16'h3F80}, {PW{1'b1}}, 0, 0);
    for (int e = 0; e < LANES; e++) check("R5 default nan", 64'(res_o[16*e +: 16]), 64'h7FC0);
    run_vec("R7 overflow", {16'h7F00, 16'hFF00, 16'h7F7F, 16'h7F80},
            {16'h4000, 16'h4000, 16'h3F80, 16'h3F80},
            {16'h0000, 16'h0000, 16'h7B00, 16'h7F80}, {PW{1'b1}}, 0, 0);
    check("R7 +inf", 64'(res_o[63:48]), 64'h7F80);
    check("R7 -inf", 64'(res_o[47:32]), 64'hFF80);
    run_vec("R6 zeros", {16'h0000, 16'h8000, 16'h4000, 16'h0000},
            {16'h3F80, 16'h3F80, 16'h4000, 16'h3F80},
            {16'h8000, 16'h8000, 16'hC080, 16'h0000}, {PW{1'b1}}, 0, 0);
    check("R6 +0 + -0", 64'(res_o[63:48]), 64'h0000);
    check("R6 -0 + -0", 64'(res_o[47:32]), 64'h8000);
    check("R6 exact cancel", 64'(res_o[31:16]), 64'h0000);
  endtask

  task automatic t_subnormal;
    run_vec("R3 subnormal", {16'h1C80, 16'h0040, 16'h1CC0, 16'h0081},
            {16'h2180, 16'h3F80, 16'h2240, 16'h3F00},
            {16'h0003, 16'h8001, 16'h807F, 16'h0000}, {PW{1'b1}}, 0, 0);
    check("R3 2^-130 + 3*2^-133", 64'(res_o[63:48]), 64'h000B);
  endtask

  task automatic t_random(input int n, input int lo, input int hi, input int clo, input int chi);
    logic [VL-1:0] a, b, c;
    logic [PW-1:0] p;
    logic [1:0]    ng;
    for (int i = 0; i < n; i++) begin
      for (int e = 0; e < LANES; e++) begin
        a[16*e +: 16] = rnd_bf(lo, hi);
        b[16*e +: 16] = rnd_bf(lo, hi);
        c[16*e +: 16] = rnd_bf(clo, chi);
      end
      p  = PW'($urandom);
      if (i % 4 == 0) p = {PW{1'b1}};
      ng = 2'($urandom);
      run_vec("R3 random", a, b, c, p, ng[0], ng[1]);
    end
  endtask

  task automatic t_backpressure;
    logic [VL-1:0] c1, c2;
    c1 = {16'h1111, 16'h2222, 16'h3333, 16'h4444};
    c2 = {16'h5555, 16'h6666, 16'h7777, 16'h0123};
    @(negedge clk);
    ready_i = 1'b0;
    src_a_i = '0; src_b_i = '0; src_c_i = c1; pred_i = '0; valid_i = 1'b1;
    @(negedge clk);
    src_c_i = c2;
    check("R9 first result", 64'(res_o), 64'(c1));
    check("R9 ready low while stalled", 64'(ready_o), 64'd0);
    repeat (2) begin
      @(negedge clk);
      check("R9 held result", 64'(res_o), 64'(c1));
      check("R9 held valid", 64'(valid_o), 64'd1);
    end
    ready_i = 1'b1;
    #0.5;
    check("R9 ready follows ready_i", 64'(ready_o), 64'd1);
    @(negedge clk);
    valid_i = 1'b0;
    check("R9 queued result", 64'(res_o), 64'(c2));
    @(negedge clk);
    check("R9 valid drops after drain", 64'(valid_o), 64'd0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_predicate();
    t_negate();
    t_specials();
    t_subnormal();
    t_random(300, 120, 135, 120, 135);
    t_random(100, 55, 70, 0, 10);
    t_backpressure();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule